// File: doc/BRIEF.md
# Peak-Current PWM Cycle Sequencer

This block produces the gate-drive pulse of a fixed-frequency, peak-current-mode switching controller. A period-start tick from the oscillator raises the drive. The pulse then ends on the first honoured trip among the synchronous comparator flags: the PWM comparator, the current limit, the short-circuit detector and the soft-start ramp. If no trip is honoured, a maximum-duty clamp ends it. Every input is already synchronous to the block clock. All times are counted in clock cycles.

Two leading-edge blanking windows open after the drive rises. A short window guards the short-circuit path. A longer window guards the current-limit, PWM and soft-start paths. While the drive is low, no trip is looked at. A skip gate with hysteresis, driven by the compensation level, holds off new pulses at light load. At each pulse end, a one-hot cause output tells downstream protection logic which source ended the pulse.

Top module: `pwm_cycle_seq`

## Requirements
- R1: While reset is held and at the first cycle after it, `drv_o` is low and `cause_o` is zero.
- R2: When `period_tick` is high at a clock edge while `en` is high, the skip gate is inactive and the drive is low, `drv_o` goes high from that edge on. It stays high until a termination.
- R3: A pulse that no trip ends stays high for exactly DMAX_CYC = PERIOD_CYC*DMAX_PCT/100 cycles, which is 16 with the defaults.
- R4: A short-circuit trip present in high cycle n of a pulse (n counted from 1) ends the pulse with width n only if n > LEB_SHORT (default 2). Otherwise it is ignored.
- R5: A current-limit or PWM trip present in high cycle n ends the pulse with width n only if n > LEB_LONG (default 4). Otherwise it is ignored.
- R6: The soft-start trip follows the long window of R5 while `ss_done` is low. While `ss_done` is high it has no effect.
- R7: The skip gate turns on at any edge where `comp_lvl` < SKIP_LO (300). It turns off only where `comp_lvl` > SKIP_HI (325). Between these levels it holds its state. While it is on, ticks raise no pulse.
- R8: `cause_o` is one-hot and is high for exactly the one cycle that follows the falling edge of the drive. Bit 0 means PWM, bit 1 current limit, bit 2 short circuit, bit 3 soft start and bit 4 duty clamp. When several sources end the pulse at the same edge, the priority is short circuit, then current limit, then soft start, then PWM, then duty clamp.
- R9: `en` low forces `drv_o` low at the next edge, with no cause pulse. Ticks are ignored while `en` is low.
- R10: A tick that arrives while the drive is high has no effect on the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global switching enable |
| period_tick | input | 1 | Start of an oscillator period |
| trip_pwm | input | 1 | PWM comparator flag |
| trip_ilim | input | 1 | Current-limit comparator flag |
| trip_scp | input | 1 | Short-circuit comparator flag |
| trip_ss | input | 1 | Soft-start comparator flag |
| ss_done | input | 1 | Soft-start ramp has finished |
| comp_lvl | input | CW | Compensation level in mV |
| drv_o | output | 1 | Gate-drive request |
| cause_o | output | 5 | One-hot pulse-termination cause |

## Verification
Embedded properties check several things on every cycle. They check that the cause vector is one-hot and coincides with a drive fall. They check that a short-circuit or long-path cause comes only after its own blanking window, and that a soft-start cause never follows an asserted `ss_done`. They also check that the drive never rises without a qualifying tick, that it stays within the duty clamp, and that disable and skip hold it low. Only the bench scenarios can show the exact pulse widths. These come from sweeping every trip source over every high cycle of the period and comparing against the arithmetic blanking and clamp model. The scenarios also cover the boundary where a trip coincides with the clamp, the hysteresis band walked up and down, priority between simultaneous trips, and ticks that are ignored during a pulse.

// File: rtl/pwm_seq_pkg.sv
`timescale 1ns/1ps
// Shared cause encoding for the PWM cycle sequencer.
// Assumes the cause bit positions below are decoded by downstream protection logic.
package pwm_seq_pkg;
    localparam int NCAUSE  = 5;
    localparam int CB_PWM  = 0;
    localparam int CB_ILIM = 1;
    localparam int CB_SCP  = 2;
    localparam int CB_SS   = 3;
    localparam int CB_DMAX = 4;
    typedef logic [NCAUSE-1:0] cause_t;
    // Termination priority, highest first.
    localparam int PRIO [NCAUSE] = '{CB_SCP, CB_ILIM, CB_SS, CB_PWM, CB_DMAX};
endpackage

// File: rtl/pwm_skip_gate.sv
`timescale 1ns/1ps
// Light-load skip gate: a comparator with hysteresis on the compensation level.
// Assumes SKIP_LO < SKIP_HI and that comp_lvl is synchronous to clk.
module pwm_skip_gate #(
    parameter int CW      = 12,
    parameter int SKIP_LO = 300,
    parameter int SKIP_HI = 325
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] comp_lvl,
    output logic          skip_o
);
    localparam logic [CW-1:0] LO_V = CW'(SKIP_LO);
    localparam logic [CW-1:0] HI_V = CW'(SKIP_HI);

    logic skip_q;

    // Enter skip below the low level, leave above the high level, hold between.
    always_ff @(posedge clk) begin
        if (!rst_n)               skip_q <= 1'b0;
        else if (comp_lvl < LO_V) skip_q <= 1'b1;
        else if (comp_lvl > HI_V) skip_q <= 1'b0;
    end

    assign skip_o = skip_q;
endmodule

// File: rtl/pwm_blank_timer.sv
`timescale 1ns/1ps
// Counts the high cycles of the current pulse and derives the two blanking
// windows and the duty-clamp request from that count.
// Assumes LEB_SHORT <= LEB_LONG < DMAX_CYC <= PERIOD_CYC.
module pwm_blank_timer #(
    parameter int PERIOD_CYC = 20,
    parameter int DMAX_CYC   = 16,
    parameter int LEB_SHORT  = 2,
    parameter int LEB_LONG   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              set_i,
    input  logic                              drv_i,
    output logic [$clog2(PERIOD_CYC+2)-1:0]   elapsed_o,
    output logic                              short_open_o,
    output logic                              long_open_o,
    output logic                              dmax_o
);
    localparam int CNTW = $clog2(PERIOD_CYC + 2);
    localparam logic [CNTW-1:0] SHORT_V = CNTW'(LEB_SHORT);
    localparam logic [CNTW-1:0] LONG_V  = CNTW'(LEB_LONG);
    localparam logic [CNTW-1:0] DMAX_V  = CNTW'(DMAX_CYC);
    localparam logic [CNTW-1:0] TOP_V   = CNTW'(PERIOD_CYC + 1);

    logic [CNTW-1:0] cnt_q;

    // cnt_q holds the 1-based index of the high cycle now in progress; zero while low.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (set_i)                  cnt_q <= CNTW'(1);
        else if (drv_i && cnt_q < TOP_V) cnt_q <= cnt_q + CNTW'(1);
        else if (!drv_i)                 cnt_q <= '0;
    end

    // The windows open only while the drive is high, so a low drive evaluates no trip.
    always_comb begin
        short_open_o = drv_i && (cnt_q > SHORT_V);
        long_open_o  = drv_i && (cnt_q > LONG_V);
        dmax_o       = drv_i && (cnt_q >= DMAX_V);
    end

    assign elapsed_o = cnt_q;

    // R3: the drive is never high beyond the clamp cycle count
    p_dmax_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drv_i |-> (cnt_q <= DMAX_V));

    // R5: the long window never opens before the short one
    p_window_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        long_open_o |-> short_open_o);
endmodule

// File: rtl/pwm_term_arb.sv
`timescale 1ns/1ps
// Fixed-priority arbiter that turns simultaneous termination requests into a
// one-hot cause, following the package priority list.
// Assumes the requests are already qualified by the blanking windows.
module pwm_term_arb
    import pwm_seq_pkg::*;
(
    input  cause_t req_i,
    output cause_t grant_o
);
    // Walk the priority list and grant the first active request.
    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < NCAUSE; i++) begin
            if (!found && req_i[PRIO[i]]) begin
                grant_o[PRIO[i]] = 1'b1;
                found            = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_cycle_seq.sv
`timescale 1ns/1ps
// Peak-current PWM cycle sequencer: sets the drive on a period tick and resets it
// on the first honoured trip or on the duty clamp, reporting the cause.
// Assumes all trip flags, ticks and comp_lvl are synchronous to clk.
module pwm_cycle_seq
    import pwm_seq_pkg::*;
#(
    parameter int PERIOD_CYC = 20,
    parameter int DMAX_PCT   = 80,
    parameter int LEB_SHORT  = 2,
    parameter int LEB_LONG   = 4,
    parameter int CW         = 12,
    parameter int SKIP_LO    = 300,
    parameter int SKIP_HI    = 325
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          period_tick,
    input  logic          trip_pwm,
    input  logic          trip_ilim,
    input  logic          trip_scp,
    input  logic          trip_ss,
    input  logic          ss_done,
    input  logic [CW-1:0] comp_lvl,
    output logic          drv_o,
    output logic [4:0]    cause_o
);
    localparam int DMAX_CYC = PERIOD_CYC * DMAX_PCT / 100;
    localparam int CNTW     = $clog2(PERIOD_CYC + 2);
    localparam logic [CNTW-1:0] SHORT_V = CNTW'(LEB_SHORT);
    localparam logic [CNTW-1:0] LONG_V  = CNTW'(LEB_LONG);

    logic            drv_q;
    cause_t          cause_q;
    logic            skip_w;
    logic            set_w;
    logic [CNTW-1:0] elapsed_w;
    logic            short_open_w, long_open_w, dmax_w;
    cause_t          req_w, grant_w;

    pwm_skip_gate #(.CW(CW), .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI)) u_skip (
        .clk(clk), .rst_n(rst_n), .comp_lvl(comp_lvl), .skip_o(skip_w)
    );

    pwm_blank_timer #(.PERIOD_CYC(PERIOD_CYC), .DMAX_CYC(DMAX_CYC),
                      .LEB_SHORT(LEB_SHORT), .LEB_LONG(LEB_LONG)) u_blank (
        .clk(clk), .rst_n(rst_n), .set_i(set_w), .drv_i(drv_q),
        .elapsed_o(elapsed_w), .short_open_o(short_open_w),
        .long_open_o(long_open_w), .dmax_o(dmax_w)
    );

    // A new pulse starts only from a low drive, enabled and outside skip.
    assign set_w = period_tick && en && !skip_w && !drv_q;

    // Qualify each trip with its blanking window and soft-start phase.
    always_comb begin
        req_w          = '0;
        req_w[CB_SCP]  = trip_scp  && short_open_w;
        req_w[CB_ILIM] = trip_ilim && long_open_w;
        req_w[CB_PWM]  = trip_pwm  && long_open_w;
        req_w[CB_SS]   = trip_ss   && long_open_w && !ss_done;
        req_w[CB_DMAX] = dmax_w;
    end

    pwm_term_arb u_arb (.req_i(req_w), .grant_o(grant_w));

    // Drive flop and one-cycle cause pulse; disable overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q   <= 1'b0;
            cause_q <= '0;
        end else if (!en) begin
            drv_q   <= 1'b0;
            cause_q <= '0;
        end else if (set_w) begin
            drv_q   <= 1'b1;
            cause_q <= '0;
        end else if (drv_q && (grant_w != '0)) begin
            drv_q   <= 1'b0;
            cause_q <= grant_w;
        end else begin
            cause_q <= '0;
        end
    end

    assign drv_o   = drv_q;
    assign cause_o = cause_q;

    // R2: a rising drive always follows a qualifying tick
    p_rise_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q) |-> $past(period_tick && en && !skip_w));

    // R8: the cause vector is one-hot or zero
    p_cause_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_q));

    // R8: a cause is reported only in the cycle after the drive fell
    p_cause_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q != '0) |-> (!drv_q && $past(drv_q)));

    // R9: disable forces the drive low without a cause
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drv_q && cause_q == '0));

    // R4: a short-circuit cause only after the short window
    p_scp_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cause_q[CB_SCP] |-> ($past(elapsed_w) > SHORT_V));

    // R5: long-path causes only after the long window
    p_long_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q[CB_ILIM] || cause_q[CB_PWM] || cause_q[CB_SS])
            |-> ($past(elapsed_w) > LONG_V));

    // R6: no soft-start cause once the ramp has ended
    p_ss_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cause_q[CB_SS] |-> $past(!ss_done));

    // R7: while skipping, a low drive stays low
    p_skip_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_w && !drv_q) |=> !drv_q);
endmodule

// File: tb/pwm_cycle_seq_bench.sv
`timescale 1ns/1ps
module pwm_cycle_seq_bench;
    localparam int PERIOD = 20;
    localparam int DMAX   = 16;
    localparam int LEB_S  = 2;
    localparam int LEB_L  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        tick = 1'b0;
    logic        t_pwm = 1'b0, t_ilim = 1'b0, t_scp = 1'b0, t_ss = 1'b0;
    logic        ssd = 1'b0;
    logic [11:0] comp = 12'd1000;
    logic        drv;
    logic [4:0]  cause;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pwm_cycle_seq u_pwm_cycle_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .period_tick(tick),
        .trip_pwm(t_pwm), .trip_ilim(t_ilim), .trip_scp(t_scp), .trip_ss(t_ss),
        .ss_done(ssd), .comp_lvl(comp), .drv_o(drv), .cause_o(cause)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One period: tick, then per high cycle j drive trips (mask bits: 0 pwm, 1 ilim, 2 scp, 3 ss)
    task automatic run_period(input logic [3:0] mask, input int ta, input int abort_at,
                              input int tick_at, output int w, output int cs, output int ncs);
        w = 0; cs = 0; ncs = 0;
        @(negedge clk); tick = 1'b1;
        for (int j = 1; j <= PERIOD; j++) begin
            @(negedge clk);
            if (drv) w++;
            if (cause != 0) begin cs = int'(cause); ncs++; end
            tick = (j == tick_at);
            {t_ss, t_scp, t_ilim, t_pwm} = (j == ta) ? mask : 4'b0;
            if (j == abort_at) en = 1'b0;
        end
        {t_ss, t_scp, t_ilim, t_pwm} = 4'b0;
        tick = 1'b0;
        en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w, cs, ncs, lim, expw, expc;
        bit hon;
        repeat (3) @(negedge clk);
        chk("R1", "drv in reset", int'(drv), 0);
        chk("R1", "cause in reset", int'(cause), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "drv after reset", int'(drv), 0);
        chk("R1", "cause after reset", int'(cause), 0);

        // R2 R3: untripped pulse is clamped
        run_period(4'b0, 0, 0, 0, w, cs, ncs);
        chk("R3", "clamp width", w, DMAX);
        chk("R8", "clamp cause", cs, 16);
        chk("R8", "cause pulse length", ncs, 1);

        // R4 R5 R6: sweep each source over every cycle, soft-start phase both ways
        for (int s = 0; s < 2; s++) begin
            ssd = (s == 1);
            for (int k = 0; k < 4; k++) begin
                for (int ta = 1; ta <= DMAX + 2; ta++) begin
                    run_period(4'(1 << k), ta, 0, 0, w, cs, ncs);
                    lim  = (k == 2) ? LEB_S : LEB_L;
                    hon  = (ta > lim) && (ta <= DMAX) && !(k == 3 && ssd);
                    expw = hon ? ta : DMAX;
                    expc = hon ? (1 << k) : 16;
                    case (k)
                        0: begin chk("R5", "pwm width", w, expw); chk("R5", "pwm cause", cs, expc); end
                        1: begin chk("R5", "ilim width", w, expw); chk("R5", "ilim cause", cs, expc); end
                        2: begin chk("R4", "scp width", w, expw); chk("R4", "scp cause", cs, expc); end
                        default: begin chk("R6", "ss width", w, expw); chk("R6", "ss cause", cs, expc); end
                    endcase
                    chk("R8", "one cause cycle", ncs, 1);
                end
            end
        end
        ssd = 1'b0;

        // R8 priority among simultaneous trips
        run_period(4'b1111, 6, 0, 0, w, cs, ncs);
        chk("R8", "all trips -> scp", cs, 4);
        run_period(4'b1011, 6, 0, 0, w, cs, ncs);
        chk("R8", "ilim over ss and pwm", cs, 2);
        run_period(4'b1001, 6, 0, 0, w, cs, ncs);
        chk("R8", "ss over pwm", cs, 8);
        run_period(4'b0001, DMAX, 0, 0, w, cs, ncs);
        chk("R8", "pwm over clamp", cs, 1);
        run_period(4'b1111, 3, 0, 0, w, cs, ncs);
        chk("R4", "only scp open at cycle 3", cs, 4);
        chk("R4", "width at cycle 3", w, 3);

        // R9 abort and disabled ticks
        run_period(4'b0, 0, 5, 0, w, cs, ncs);
        chk("R9", "abort width", w, 5);
        chk("R9", "abort no cause", ncs, 0);
        en = 1'b0;
        run_period(4'b0, 0, 0, 0, w, cs, ncs);
        chk("R9", "tick ignored when disabled", w, 0);

        // R10 tick during pulse
        run_period(4'b0, 0, 0, 8, w, cs, ncs);
        chk("R10", "mid-pulse tick width", w, DMAX);

        // R7 hysteresis walk
        @(negedge clk); comp = 12'd299;
        run_period(4'b0, 0, 0, 0, w, cs, ncs);
        chk("R7", "below low blocks", w, 0);
        chk("R7", "no cause in skip", ncs, 0);
        comp = 12'd310;
        run_period(4'b0, 0, 0, 0, w, cs, ncs);
        chk("R7", "band holds skip", w, 0);
        comp = 12'd325;
        run_period(4'b0, 0, 0, 0, w, cs, ncs);
        chk("R7", "at high level still skip", w, 0);
        comp = 12'd326;
        run_period(4'b0, 0, 0, 0, w, cs, ncs);
        chk("R7", "above high resumes", w, DMAX);
        comp = 12'd310;
        run_period(4'b0, 0, 0, 0, w, cs, ncs);
        chk("R7", "band holds run", w, DMAX);
        comp = 12'd300;
        run_period(4'b0, 0, 0, 0, w, cs, ncs);
        chk("R7", "at low level still runs", w, DMAX);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule